// File: doc/BRIEF.md
# Key-Unlocked Configuration Index/Data Port

This block is the configuration-space front end of a legacy I/O controller. The host's address decoder turns byte writes to the index port (I/O address 0x2E) into `idx_wr_i` and turns accesses to the data port (0x2F) into `dat_wr_i` and `dat_rd_i`. The port starts locked. Index-port writes feed a sequence matcher until the four-byte key 0x87, 0x01, 0x55, 0x55 has been seen. While locked, data-port reads return 0xFF and data-port writes do nothing.

Once unlocked, an index-port write picks a configuration register, and the data port then reads or writes that register. A small set of global registers lives below index 0x30:
- a logical-device selector at 0x07,
- the 16-bit chip identifier at 0x20 (high byte) and 0x21 (low byte),
- a revision byte at 0x22,
- a lock control at 0x02.

Indices from 0x30 up are forwarded to the device banks over a simple strobe interface. That interface carries the selected logical device number, so each bank decodes its own registers. Writing 0x02 to index 0x02 locks the port again.

Top module: `cfg_key_port`

## Requirements
- R1: After reset the port is locked, `dev_ldn_o` is 0x00 and `dev_addr_o` (the index register) is 0x00.
- R2: Index-port writes of 0x87, 0x01, 0x55, 0x55, in that order, unlock the port. The unlock takes effect at the clock edge of the fourth write, so the next data access is served.
- R3: While locked, an index-port byte that differs from the next expected key byte restarts the matcher. If that byte is 0x87, it counts as the first key byte.
- R4: While locked:
  - a data-port read returns 0xFF;
  - a data-port write changes no register and raises no `dev_wr_o`;
  - index-port writes leave the index register unchanged.
- R5: While unlocked, an index-port write loads the index register, which appears on `dev_addr_o` after that edge. The result of a data-port read appears on `rdata_o` one cycle after the cycle in which `dat_rd_i` is high.
- R6: Index 0x07 holds the logical device number. A data write there loads it, a data read returns it, and it drives `dev_ldn_o`.
- R7: The following global registers are read-only and ignore data writes:
  - index 0x20 returns `CHIP_ID[15:8]` (0x87 by default);
  - index 0x21 returns `CHIP_ID[7:0]` (0x28);
  - index 0x22 returns the revision in bits 3:0, taken from `CHIP_REV[3:0]` (0xA), with bits 7:4 read as 0.

  Any other index below 0x30, except 0x07, reads 0x00.
- R8: For indices 0x30 and above, a data write raises `dev_wr_o` in the same cycle, with `dev_addr_o`, `dev_ldn_o` and `dev_wdata_o` valid. A data read raises `dev_rd_o` in the same cycle and returns the sampled `dev_rdata_i`. Indices below 0x30 never strobe the banks, whichever logical device is selected.
- R9: A data write of 0x02 while the index is 0x02 locks the port at that edge. Any other value written to index 0x02 leaves the port unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| idx_wr_i | input | 1 | Write strobe for the index port |
| dat_wr_i | input | 1 | Write strobe for the data port |
| dat_rd_i | input | 1 | Read strobe for the data port |
| wdata_i | input | 8 | Host write byte |
| rdata_o | output | 8 | Data-port read result, registered |
| dev_ldn_o | output | 8 | Selected logical device number |
| dev_addr_o | output | 8 | Current index register |
| dev_wdata_o | output | 8 | Write byte to the device banks |
| dev_wr_o | output | 1 | Device-bank write strobe |
| dev_rd_o | output | 1 | Device-bank read strobe |
| dev_rdata_i | input | 8 | Read byte from the selected bank |

## Verification
The bank strobes `dev_wr_o` and `dev_rd_o` are combinational in the strobe cycle, so the bench samples them 1 ns after driving an access, before the clock edge. Index, logical-device and lock changes land at the edge that ends the access cycle. `rdata_o` is registered one cycle after `dat_rd_i`. The bench therefore drives every access on a falling edge, holds it for one full cycle, and compares `dev_addr_o`, `dev_ldn_o`, `rdata_o` and the lock state seen through reads at the next falling edge. A bench model of the key matcher, index, selector and lock predicts each value in step with those edges.

// File: rtl/cfg_key_port_pkg.sv
package cfg_key_port_pkg;
  typedef logic [7:0] byte_t;

  localparam int KEY_LEN = 4;
  localparam int KEY_CW  = $clog2(KEY_LEN);
  localparam byte_t UNLOCK_KEY [KEY_LEN] = '{8'h87, 8'h01, 8'h55, 8'h55};

  localparam byte_t IDX_CTRL   = 8'h02;
  localparam byte_t LOCK_VAL   = 8'h02;
  localparam byte_t IDX_LDN    = 8'h07;
  localparam byte_t IDX_ID_HI  = 8'h20;
  localparam byte_t IDX_ID_LO  = 8'h21;
  localparam byte_t IDX_REV    = 8'h22;
  localparam byte_t BANK_BASE  = 8'h30;
  localparam byte_t LOCKED_RD  = 8'hFF;
endpackage

// File: rtl/cfg_key_matcher.sv
module cfg_key_matcher
  import cfg_key_port_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  idx_wr_i,
  input  byte_t wdata_i,
  input  logic  lock_req_i,
  output logic  unlocked_o
);
  localparam logic [KEY_CW-1:0] LAST = KEY_CW'(KEY_LEN - 1);

  logic [KEY_CW-1:0] cnt_q;
  logic              unl_q;
  logic              hit;

  assign hit = (wdata_i == UNLOCK_KEY[cnt_q]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unl_q <= 1'b0;
      cnt_q <= '0;
    end else if (lock_req_i) begin
      unl_q <= 1'b0;
      cnt_q <= '0;
    end else if (!unl_q && idx_wr_i) begin
      if (hit) begin
        if (cnt_q == LAST) begin
          unl_q <= 1'b1;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + KEY_CW'(1);
        end
      end else begin
        // a stray first-key byte restarts the sequence at position one
        cnt_q <= (wdata_i == UNLOCK_KEY[0]) ? KEY_CW'(1) : '0;
      end
    end
  end

  assign unlocked_o = unl_q;

  // R2
  a_r2_unlock_needs_last_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(unl_q) |-> ($past(idx_wr_i) && $past(wdata_i) == UNLOCK_KEY[KEY_LEN-1]
                      && $past(cnt_q) == LAST));

  // R3
  a_r3_mismatch_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!unl_q && !lock_req_i && idx_wr_i && !hit && wdata_i != UNLOCK_KEY[0])
      |=> (cnt_q == '0 && !unl_q));
endmodule

// File: rtl/cfg_index_regs.sv
module cfg_index_regs
  import cfg_key_port_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  unlocked_i,
  input  logic  idx_wr_i,
  input  logic  dat_wr_i,
  input  byte_t wdata_i,
  output byte_t index_o,
  output byte_t ldn_o,
  output logic  lock_req_o
);
  byte_t idx_q, ldn_q;
  logic  ldn_we;

  assign ldn_we     = unlocked_i && dat_wr_i && (idx_q == IDX_LDN);
  assign lock_req_o = unlocked_i && dat_wr_i && (idx_q == IDX_CTRL) && (wdata_i == LOCK_VAL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      ldn_q <= '0;
    end else begin
      if (unlocked_i && idx_wr_i) idx_q <= wdata_i;
      if (ldn_we)                 ldn_q <= wdata_i;
    end
  end

  assign index_o = idx_q;
  assign ldn_o   = ldn_q;

  // R4
  a_r4_index_frozen_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unlocked_i |=> $stable(idx_q));

  // R6
  a_r6_ldn_only_by_data_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(unlocked_i && dat_wr_i && idx_q == IDX_LDN) |=> $stable(ldn_q));
endmodule

// File: rtl/cfg_read_path.sv
module cfg_read_path
  import cfg_key_port_pkg::*;
#(
  parameter logic [15:0] CHIP_ID  = 16'h8728,
  parameter logic [7:0]  CHIP_REV = 8'h1A
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  unlocked_i,
  input  logic  rd_i,
  input  byte_t index_i,
  input  byte_t ldn_i,
  input  byte_t dev_rdata_i,
  output byte_t rdata_o
);
  byte_t glob_val, rd_val, rdata_q;

  always_comb begin
    unique case (index_i)
      IDX_LDN:   glob_val = ldn_i;
      IDX_ID_HI: glob_val = CHIP_ID[15:8];
      IDX_ID_LO: glob_val = CHIP_ID[7:0];
      IDX_REV:   glob_val = {4'h0, CHIP_REV[3:0]};
      default:   glob_val = 8'h00;
    endcase
  end

  always_comb begin
    if (!unlocked_i)                rd_val = LOCKED_RD;
    else if (index_i >= BANK_BASE) rd_val = dev_rdata_i;
    else                            rd_val = glob_val;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= LOCKED_RD;
    else if (rd_i) rdata_q <= rd_val;
  end

  assign rdata_o = rdata_q;

  // R4
  a_r4_locked_read_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !unlocked_i) |=> (rdata_o == LOCKED_RD));

  // R7
  a_r7_rev_high_nibble_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && unlocked_i && index_i == IDX_REV) |=> (rdata_o[7:4] == 4'h0));
endmodule

// File: rtl/cfg_key_port.sv
module cfg_key_port
  import cfg_key_port_pkg::*;
#(
  parameter logic [15:0] CHIP_ID  = 16'h8728,
  parameter logic [7:0]  CHIP_REV = 8'h1A
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       idx_wr_i,
  input  logic       dat_wr_i,
  input  logic       dat_rd_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic [7:0] dev_ldn_o,
  output logic [7:0] dev_addr_o,
  output logic [7:0] dev_wdata_o,
  output logic       dev_wr_o,
  output logic       dev_rd_o,
  input  logic [7:0] dev_rdata_i
);
  logic  unlocked, lock_req, bank_sel;
  byte_t index, ldn;

  cfg_key_matcher u_match (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .idx_wr_i   (idx_wr_i),
    .wdata_i    (wdata_i),
    .lock_req_i (lock_req),
    .unlocked_o (unlocked)
  );

  cfg_index_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .unlocked_i (unlocked),
    .idx_wr_i   (idx_wr_i),
    .dat_wr_i   (dat_wr_i),
    .wdata_i    (wdata_i),
    .index_o    (index),
    .ldn_o      (ldn),
    .lock_req_o (lock_req)
  );

  cfg_read_path #(.CHIP_ID(CHIP_ID), .CHIP_REV(CHIP_REV)) u_rd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .unlocked_i  (unlocked),
    .rd_i        (dat_rd_i),
    .index_i     (index),
    .ldn_i       (ldn),
    .dev_rdata_i (dev_rdata_i),
    .rdata_o     (rdata_o)
  );

  assign bank_sel    = unlocked && (index >= BANK_BASE);
  assign dev_wr_o    = bank_sel && dat_wr_i;
  assign dev_rd_o    = bank_sel && dat_rd_i;
  assign dev_addr_o  = index;
  assign dev_ldn_o   = ldn;
  assign dev_wdata_o = wdata_i;

  // R9
  a_r9_lock_on_ctrl_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unlocked && dat_wr_i && index == IDX_CTRL && wdata_i == LOCK_VAL) |=> !unlocked);

  // R8
  a_r8_no_bank_strobe_below_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_wr_o || dev_rd_o) |-> (unlocked && dev_addr_o >= BANK_BASE));
endmodule

// File: tb/tb_cfg_key_port.sv
`timescale 1ns/1ps
module tb_cfg_key_port;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       idx_wr = 0, dat_wr = 0, dat_rd = 0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, dev_ldn, dev_addr, dev_wdata, dev_rdata;
  logic       dev_wr, dev_rd;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench model
  bit       m_unl = 0;
  int       m_cnt = 0;
  logic [7:0] m_idx = '0, m_ldn = '0;
  logic [7:0] key [4] = '{8'h87, 8'h01, 8'h55, 8'h55};

  always #2 clk = ~clk;

  assign dev_rdata = dev_addr ^ {dev_ldn[3:0], 4'h5};

  cfg_key_port dut (
    .clk_i(clk), .rst_ni(rst_n), .idx_wr_i(idx_wr), .dat_wr_i(dat_wr),
    .dat_rd_i(dat_rd), .wdata_i(wdata), .rdata_o(rdata), .dev_ldn_o(dev_ldn),
    .dev_addr_o(dev_addr), .dev_wdata_o(dev_wdata), .dev_wr_o(dev_wr),
    .dev_rd_o(dev_rd), .dev_rdata_i(dev_rdata)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read();
    if (!m_unl) return 8'hFF;
    if (m_idx >= 8'h30) return m_idx ^ {m_ldn[3:0], 4'h5};
    case (m_idx)
      8'h07: return m_ldn;
      8'h20: return 8'h87;
      8'h21: return 8'h28;
      8'h22: return 8'h0A;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string rd_req();
    if (!m_unl) return "R4";
    if (m_idx >= 8'h30) return "R8";
    if (m_idx == 8'h07) return "R6";
    return "R7";
  endfunction

  task automatic idx_write(logic [7:0] b);
    @(negedge clk);
    idx_wr = 1; wdata = b;
    @(negedge clk);
    idx_wr = 0;
    if (m_unl) m_idx = b;
    else if (b == key[m_cnt]) begin
      if (m_cnt == 3) begin m_unl = 1; m_cnt = 0; end
      else m_cnt++;
    end else m_cnt = (b == 8'h87) ? 1 : 0;
    chk(m_unl ? "R5 index" : "R4 index", dev_addr, m_idx);
  endtask

  task automatic dat_write(logic [7:0] b);
    bit bank;
    @(negedge clk);
    dat_wr = 1; wdata = b;
    #1;
    bank = m_unl && m_idx >= 8'h30;
    chk("R8 dev_wr", {7'd0, dev_wr}, {7'd0, bank});
    if (bank) begin
      chk("R8 dev_wdata", dev_wdata, b);
      chk("R8 dev_addr", dev_addr, m_idx);
    end
    @(negedge clk);
    dat_wr = 0;
    if (m_unl && m_idx == 8'h07) m_ldn = b;
    if (m_unl && m_idx == 8'h02 && b == 8'h02) m_unl = 0;
    chk("R6 ldn", dev_ldn, m_ldn);
  endtask

  task automatic dat_read();
    bit bank;
    @(negedge clk);
    dat_rd = 1;
    #1;
    bank = m_unl && m_idx >= 8'h30;
    chk("R8 dev_rd", {7'd0, dev_rd}, {7'd0, bank});
    @(negedge clk);
    dat_rd = 0;
    chk({rd_req(), " R5 read"}, rdata, exp_read());
  endtask

  task automatic unlock();
    idx_write(8'h87); idx_write(8'h01); idx_write(8'h55); idx_write(8'h55);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 ldn", dev_ldn, 8'h00);
    chk("R1 index", dev_addr, 8'h00);
    dat_read();                                  // R1 locked at reset
    dat_write(8'h33);                            // R4 write ignored
    idx_write(8'h30);                            // R4 index frozen
    dat_read();
    // R3: a second 0x87 mid-sequence restarts at position one
    idx_write(8'h87); idx_write(8'h01); idx_write(8'h87);
    dat_read();
    idx_write(8'h01); idx_write(8'h55);
    dat_read();
    idx_write(8'h55);
    chk("R2 unlocked", {7'd0, m_unl}, 8'd1);
    idx_write(8'h20); dat_read();                // R2 R7 id high
    dat_write(8'h11); dat_read();                // R7 read-only
    idx_write(8'h21); dat_read();
    idx_write(8'h22); dat_read();
    idx_write(8'h10); dat_read();
    idx_write(8'h07); dat_write(8'h07); dat_read(); // R6
    idx_write(8'h30); dat_write(8'hA5); dat_read(); // R8
    idx_write(8'h25); dat_write(8'h5A); dat_read(); // R8 globals not forwarded
    idx_write(8'h02); dat_write(8'h03);          // R9 wrong value
    idx_write(8'h20); dat_read();
    idx_write(8'h02); dat_write(8'h02);          // R9 lock
    chk("R9 locked", {7'd0, m_unl}, 8'd0);
    dat_read();
    // R3: plain mismatch restarts from the beginning
    idx_write(8'h87); idx_write(8'h55); idx_write(8'h01); idx_write(8'h55); idx_write(8'h55);
    dat_read();
    unlock();
    dat_read();
    // constrained random
    void'($urandom(32'd1234));
    for (int i = 0; i < 600; i++) begin
      int op;
      logic [7:0] b;
      op = $urandom_range(0, 9);
      case ($urandom_range(0, 7))
        0: b = 8'h87; 1: b = 8'h01; 2: b = 8'h55; 3: b = 8'h02;
        4: b = 8'h07; 5: b = 8'h20 + 8'($urandom_range(0, 3));
        6: b = 8'h30 + 8'($urandom_range(0, 15));
        default: b = 8'($urandom);
      endcase
      if (op < 4) idx_write(b);
      else if (op < 7) dat_write(b);
      else dat_read();
    end
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule